// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system watchdog reached through a small 16-bit register port. A prescaler divides the clock into coarse ticks (0.6 s in silicon; the divide value is a parameter so a bench can shorten it). A 10-bit down-counter steps once per tick while the block is not halted. Software keeps the system alive by writing the reload register, which puts the counter back to the programmed initial value.

Escalation happens in two stages. When the count runs out the first time, a timeout flag is set, a one-cycle event pulse is issued and the counter restarts from the initial value. If the count runs out again while that flag is still set, a second-timeout flag is set and a one-cycle reset request is issued, unless the no-reboot control bit blocks it. Clearing the first flag in time restarts the whole sequence. The status flags are cleared by writing 1. One control bit is plain storage that inverts whenever a 1 is written to it.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the control register (offset 0x08) reads 0x0801 (halt bit 11 = 1, no-reboot bit 0 = 1), the initial value (offset 0x12) reads 0x0004, both status registers (offsets 0x04, 0x06) read 0, and the count (offset 0x00) reads 4 and does not change while halted.
- R2: A read strobe returns data and a valid strobe one clock later; offsets other than 0x00, 0x04, 0x06, 0x08 and 0x12 read as 0.
- R3: The initial value is the low 10 bits at offset 0x12; the upper 6 bits read 0. A write whose low 10 bits are 0 to 3 is ignored and the previous value is kept.
- R4: Any write to offset 0x00 loads the counter with the initial value and restarts the tick phase; reading offset 0x00 returns the current count in bits 9:0.
- R5: With the halt bit (offset 0x08 bit 11) at 0 the counter steps down once every TICK_DIV clocks; with it at 1 the count holds.
- R6: A tick that finds the count at 1 is an expiry and reloads the counter with the initial value. The first expiry of a sequence sets bit 3 at offset 0x04 and pulses `first_expiry` for one cycle, TICK_DIV times the initial value clocks after the reload or halt-clear write.
- R7: An expiry while bit 3 at offset 0x04 is set sets bit 1 at offset 0x06 and, with no-reboot clear, pulses `reset_req` for one cycle and sets the boot flag, bit 2 at offset 0x06.
- R8: With the no-reboot bit (offset 0x08 bit 0) set, a second expiry still sets bit 1 at offset 0x06 but neither pulses `reset_req` nor sets the boot flag.
- R9: Status bits clear when written with 1 (bit 3 at 0x04, bits 1 and 2 at 0x06); writing 0 leaves them. Clearing bit 3 before the next expiry makes that expiry a first-stage one again.
- R10: Bit 8 at offset 0x08 inverts when written with 1, is unchanged when written with 0, and has no effect on the timer; other control bits than 0, 8 and 11 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| reset_req | output | 1 | One-cycle system reset request on second expiry |
| first_expiry | output | 1 | One-cycle event on first expiry |

## Verification
Read data is due one clock after the edge that takes the read strobe, so the bench drives on the falling edge and samples on the next falling edge. An expiry pulse is due exactly TICK_DIV times the initial value edges after the edge that takes the reload or halt-clear write; the bench keeps an edge counter, stamps each write with the edge that took it and each pulse with the edge that raised it, and compares the difference. When the counter is halted mid-run, the expected frozen count is derived from how many tick edges, counted from the halt-clear edge up to and including the halt edge, have passed.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int TICK_DIV = 30_000_000,
  parameter int AW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          bus_rvalid,
  output logic          reset_req,
  output logic          first_expiry
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = 10;
  localparam logic [CW-1:0] MIN_INIT  = CW'(4);
  localparam logic [AW-1:0] A_RLD   = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT1 = AW'(8'h04);
  localparam logic [AW-1:0] A_STAT2 = AW'(8'h06);
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h08);
  localparam logic [AW-1:0] A_INIT  = AW'(8'h12);

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt, init_v;
  logic halt, noreboot, flip, to1, to2, boot;

  wire wr_rld   = bus_wr && bus_addr == A_RLD;
  wire wr_stat1 = bus_wr && bus_addr == A_STAT1;
  wire wr_stat2 = bus_wr && bus_addr == A_STAT2;
  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_init  = bus_wr && bus_addr == A_INIT;

  wire tick   = !halt && pre == PW'(TICK_DIV - 1);
  wire expire = tick && cnt <= CW'(1) && !wr_rld;
  wire first  = expire && !to1;
  wire second = expire && to1;

  wire unused_wdata = ^{bus_wdata[15:12], bus_wdata[10]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      pre <= '0;
    else if (halt || wr_rld || tick) pre <= '0;
    else                             pre <= pre + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= MIN_INIT;
    else if (wr_rld || expire) cnt <= init_v;
    else if (tick)             cnt <= cnt - CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      halt     <= 1'b1;
      noreboot <= 1'b1;
      flip     <= 1'b0;
    end else if (wr_ctrl) begin
      halt     <= bus_wdata[11];
      noreboot <= bus_wdata[0];
      flip     <= flip ^ bus_wdata[8];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                   init_v <= MIN_INIT;
    else if (wr_init && bus_wdata[CW-1:0] >= MIN_INIT) init_v <= bus_wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         to1 <= 1'b0;
    else if (first)                     to1 <= 1'b1;
    else if (wr_stat1 && bus_wdata[3])  to1 <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         to2 <= 1'b0;
    else if (second)                    to2 <= 1'b1;
    else if (wr_stat2 && bus_wdata[1])  to2 <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         boot <= 1'b0;
    else if (second && !noreboot)       boot <= 1'b1;
    else if (wr_stat2 && bus_wdata[2])  boot <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reset_req    <= 1'b0;
      first_expiry <= 1'b0;
    end else begin
      reset_req    <= second && !noreboot;
      first_expiry <= first;
    end

  logic [15:0] rd_mux;
  always_comb
    case (bus_addr)
      A_RLD:   rd_mux = {6'b0, cnt};
      A_STAT1: rd_mux = {12'b0, to1, 3'b0};
      A_STAT2: rd_mux = {13'b0, boot, to2, 1'b0};
      A_CTRL:  rd_mux = {4'b0, halt, 2'b0, flip, 7'b0, noreboot};
      A_INIT:  rd_mux = {6'b0, init_v};
      default: rd_mux = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rdata  <= bus_rd ? rd_mux : '0;
      bus_rvalid <= bus_rd;
    end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd,
  input logic       bus_rvalid,
  input logic       first_expiry,
  input logic       reset_req,
  input logic       to1,
  input logic       boot,
  input logic       noreboot,
  input logic       halt,
  input logic       wr_rld,
  input logic [9:0] cnt,
  input logic [9:0] init_v
);
  p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  p_rvalid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  p_init_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_v >= 10'd4);
  p_count_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && $past(halt) && !$past(wr_rld)) |-> $stable(cnt));
  p_first_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    first_expiry |-> to1);
  p_first_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    first_expiry |=> !first_expiry);
  p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  p_rst_sets_boot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> boot);
  p_noreboot_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !$past(noreboot));
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .first_expiry(first_expiry), .reset_req(reset_req), .to1(to1),
  .boot(boot), .noreboot(noreboot), .halt(halt), .wr_rld(wr_rld),
  .cnt(cnt), .init_v(init_v)
);

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  localparam int DIV = 4;
  localparam int AW  = 5;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic bus_rvalid, reset_req, first_expiry;

  wdt_two_stage #(.TICK_DIV(DIV), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .reset_req(reset_req), .first_expiry(first_expiry)
  );

  always #5 clk = ~clk;

  int cyc = 0, nchk = 0, nfail = 0;
  int fe_cnt = 0, fe_last = -1, rr_cnt = 0, rr_last = -1, wr_at = 0;
  bit done = 0;
  logic [15:0] rd_val;
  logic rd_ok;

  int m_init = 4, m_cnt = 4, m_flip = 0, m_nr = 1, m_halt = 1, m_s1 = 0, m_s2 = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (first_expiry) begin fe_cnt++; fe_last = cyc; end
    if (reset_req)    begin rr_cnt++; rr_last = cyc; end
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 0;
    wr_at = cyc;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bus_rd = 1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 0;
    rd_val = bus_rdata; rd_ok = bus_rvalid;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      'h00: return m_cnt;
      'h04: return m_s1;
      'h06: return m_s2;
      'h08: return (m_halt << 11) | (m_flip << 8) | m_nr;
      'h12: return m_init;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      'h00: return "R4 count read";
      'h04, 'h06: return "R9 status read";
      'h08: return "R10 control read";
      'h12: return "R3 initial read";
      default: return "R2 unmapped read";
    endcase
  endfunction

  function automatic int expiry_at(input int start, input int n, input int k);
    return start + k * n * DIV;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int addrs[8] = '{'h00, 'h04, 'h06, 'h08, 'h12, 'h02, 'h0A, 'h1E};
    int e0, h, k;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd('h08); check("R1 control reset", rd_val, 'h0801);
    check("R2 rvalid", rd_ok, 1);
    rd('h12); check("R1 initial reset", rd_val, 4);
    rd('h04); check("R1 status1 reset", rd_val, 0);
    rd('h06); check("R1 status2 reset", rd_val, 0);
    repeat (40) @(negedge clk);
    rd('h00); check("R1 count stopped", rd_val, 4);
    @(negedge clk); check("R2 rvalid drops", bus_rvalid, 0);
    rd('h1E); check("R2 unmapped", rd_val, 0);

    // Random register traffic with the timer halted
    for (int i = 0; i < 300; i++) begin
      int op = $urandom % 6;
      int d;
      case (op)
        0: begin
          d = ($urandom % 2) ? ($urandom % 8) | ($urandom & 'hFC00) : ($urandom & 'hFFFF);
          wr('h12, d);
          if ((d & 'h3FF) >= 4) m_init = d & 'h3FF;
        end
        1: begin
          d = ($urandom & 'hFFFF) | 'h0800;
          wr('h08, d);
          m_flip = m_flip ^ ((d >> 8) & 1);
          m_nr = d & 1;
        end
        2: begin wr('h00, $urandom & 'hFFFF); m_cnt = m_init; end
        3: wr(($urandom % 2) ? 'h04 : 'h06, $urandom & 'hFFFF);
        default: begin
          int a = addrs[$urandom % 8];
          rd(a);
          check(tag_of(a), rd_val, exp_rd(a));
        end
      endcase
    end

    // R3 directed: small value ignored, upper bits dropped
    wr('h12, 'hFC07); m_init = 7;
    rd('h12); check("R3 upper bits", rd_val, 7);
    wr('h12, 'h0003);
    rd('h12); check("R3 value 3 ignored", rd_val, 7);
    wr('h12, 5); m_init = 5;

    // R10 flip bit: write 1 inverts, write 0 keeps
    wr('h08, 'h0900); m_flip ^= 1; m_nr = 0;
    rd('h08); check("R10 flip on 1", rd_val, exp_rd('h08));
    wr('h08, 'h0800);
    rd('h08); check("R10 flip kept on 0", rd_val, exp_rd('h08));

    // R4 reload while halted
    wr('h00, 'h1234); m_cnt = 5;
    rd('h00); check("R4 reload value", rd_val, 5);

    // R5 counting then hold
    wr('h08, 'h0000 | m_nr); e0 = wr_at;
    wait_until(e0 + 9);
    wr('h08, 'h0800 | m_nr); h = wr_at;
    k = (h - e0) / DIV;
    rd('h00); check("R5 count after ticks", rd_val, 5 - k);
    repeat (30) @(negedge clk);
    rd('h00); check("R5 count holds halted", rd_val, 5 - k);

    // R6 first expiry, R9 restart, R7 second expiry
    wr('h00, 0);
    wr('h08, 'h0000); e0 = wr_at;
    wait_until(expiry_at(e0, 5, 1) + 1);
    check("R6 first pulse count", fe_cnt, 1);
    check("R6 first pulse time", fe_last, expiry_at(e0, 5, 1));
    rd('h04); check("R6 status1 set", rd_val, 'h0008);
    wr('h04, 'h0008);
    wait_until(expiry_at(e0, 5, 2) + 1);
    check("R9 restart is first stage", fe_cnt, 2);
    check("R9 restart time", fe_last, expiry_at(e0, 5, 2));
    check("R9 no reset after clear", rr_cnt, 0);
    wait_until(expiry_at(e0, 5, 3) + 1);
    check("R7 reset pulse count", rr_cnt, 1);
    check("R7 reset pulse time", rr_last, expiry_at(e0, 5, 3));
    check("R7 no extra first pulse", fe_cnt, 2);
    wr('h08, 'h0800);
    rd('h06); check("R7 status2 second and boot", rd_val, 'h0006);

    // R9 write-one-to-clear
    wr('h06, 'h0000); rd('h06); check("R9 status2 write 0", rd_val, 'h0006);
    wr('h06, 'h0002); rd('h06); check("R9 clear second", rd_val, 'h0004);
    wr('h06, 'h0004); rd('h06); check("R9 clear boot", rd_val, 0);
    wr('h04, 'h0000); rd('h04); check("R9 status1 write 0", rd_val, 'h0008);
    wr('h04, 'h0008); rd('h04); check("R9 clear status1", rd_val, 0);

    // R8 no-reboot
    wr('h00, 0);
    wr('h08, 'h0001); e0 = wr_at;
    wait_until(expiry_at(e0, 5, 2) + 1);
    check("R8 first pulse time", fe_last, expiry_at(e0, 5, 1));
    check("R8 reset suppressed", rr_cnt, 1);
    wr('h08, 'h0801);
    rd('h06); check("R8 second set boot clear", rd_val, 'h0002);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule